// File: doc/BRIEF.md
# Asynchronous DRAM Power-Up and Refresh Sequencer

This block sits beside the host's read/write sequencer for an asynchronous DRAM with a multiplexed row address. After reset it waits out the startup pause the device needs. It then runs a fixed burst of wake-up refresh cycles and raises `ready`. From that point it keeps the whole array refreshed by spreading one refresh cycle per row evenly over the retention window.

The read/write sequencer asks for the memory with `acc_req`. It may drive the strobes only while `acc_grant` is high, and it hands the memory back with a one-cycle `acc_done`. A refresh that falls due during an access waits until that access ends. If the access runs so long that a second refresh falls due before the first was served, the retention budget counts as broken. The controller then drops `ready` and replays the whole wake-up burst.

The default refresh style is CAS-before-RAS, which relies on the device's own row counter. A parameter selects RAS-only refresh instead. In that mode an internal row counter drives `row_addr`, and `CAS\` stays high. All times are clock counts derived from the clock frequency parameter.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is applied and just after it, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, `ready` and `acc_grant` are 0, and `row_addr` is 0.
- R2: After reset is released, `ras_n` and `cas_n` stay 1 for at least CLK_MHZ*PAUSE_US clocks.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles (8 by default) are issued before `ready` rises, and `ready` stays 0 until the last of them completes.
- R4: In CAS-before-RAS mode (RAS_ONLY=0), `cas_n` is 0 on every falling edge of `ras_n`, and `we_n` and `oe_n` are 1 at every refresh cycle.
- R5: Each refresh cycle lowers `cas_n` exactly T_CSR clocks before `ras_n` in CAS-before-RAS mode. `ras_n` stays low for exactly T_RAS clocks. Both strobes then stay high for at least T_RP clocks before the next cycle.
- R6: Once ready, with no access traffic, one refresh cycle is issued every floor(CLK_MHZ*WINDOW_US/ROWS) clocks.
- R7: `acc_grant` rises in answer to `acc_req` when no refresh is due, and stays high until `acc_done`. It is never high while `ras_n` or `cas_n` is 0.
- R8: A refresh that falls due during a granted access is not issued during the access. It is issued right after `acc_done`, and `ready` stays 1.
- R9: If a refresh falls due while the previous one is still waiting, `ready` drops to 0 after the access ends. WAKE_CYCLES refresh cycles are then issued again before `ready` returns to 1.
- R10: In RAS-only mode (RAS_ONLY=1), `cas_n` stays 1. `row_addr` during each refresh cycle counts 0, 1, 2, … from reset, including the wake-up cycles, and wraps from ROWS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Read/write sequencer asks for the memory |
| acc_done | input | 1 | One-cycle pulse: sequencer releases the memory |
| acc_grant | output | 1 | Sequencer may drive the memory |
| ready | output | 1 | Initialisation complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| oe_n | output | 1 | Output enable, active low (held high) |
| row_addr | output | ROW_W | Refresh row in RAS-only mode, 0 otherwise |

## Verification
The assertions assume the sequencer pulses `acc_done` only while it holds a grant, and that a strobe cycle is only started while the strobe engine is idle. The stimulus keeps to this: it raises `acc_req` only from an idle bus, waits for `acc_grant`, and releases with a single `acc_done` pulse. Access lengths are aligned to a just-started refresh, so each one spans either one or two refresh intervals as intended. A second, small RAS-only instance has no access traffic and is used to reach the row wrap quickly.

// File: rtl/dram_rc_pkg.sv
package dram_rc_pkg;
  typedef enum logic [2:0] {
    C_PAUSE, C_WAKE, C_IDLE, C_ACCESS, C_REFRESH
  } ctl_state_t;

  typedef enum logic [1:0] {
    S_IDLE, S_LEAD, S_ACT, S_PRE
  } strobe_state_t;
endpackage

// File: rtl/rc_interval_timer.sv
module rc_interval_timer #(
  parameter int PERIOD = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rc_row_counter.sv
module rc_row_counter #(
  parameter int ROWS  = 4096,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (inc) row_d = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;

  p_row_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && row_q == ROW_W'(ROWS - 1)) |=> (row_q == '0));
endmodule

// File: rtl/rc_strobe_seq.sv
module rc_strobe_seq
  import dram_rc_pkg::*;
#(
  parameter int T_CSR = 2,
  parameter int T_RAS = 4,
  parameter int T_RP  = 3,
  parameter bit CBR   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int TMAX = (T_RAS > T_CSR) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                        : ((T_CSR > T_RP) ? T_CSR : T_RP);
  localparam int CW = $clog2(TMAX + 1);

  strobe_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      S_IDLE: if (start) begin st_d = S_LEAD; cnt_d = CW'(T_CSR - 1); end
      S_LEAD: if (cnt_q == '0) begin st_d = S_ACT; cnt_d = CW'(T_RAS - 1); end
              else cnt_d = cnt_q - 1'b1;
      S_ACT:  if (cnt_q == '0) begin st_d = S_PRE; cnt_d = CW'(T_RP - 1); end
              else cnt_d = cnt_q - 1'b1;
      S_PRE:  if (cnt_q == '0) st_d = S_IDLE;
              else cnt_d = cnt_q - 1'b1;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy  = (st_q != S_IDLE);
  assign done  = (st_q == S_PRE) && (cnt_q == '0);
  assign ras_n = (st_q != S_ACT);

  generate
    if (CBR) begin : g_cbr
      // Column strobe leads the row strobe and is held through it.
      assign cas_n = !((st_q == S_LEAD) || (st_q == S_ACT));
      p_cas_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));
    end else begin : g_ras_only
      // Lead phase becomes an address setup phase with both strobes high.
      assign cas_n = 1'b1;
    end
  endgenerate

  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> (ras_n && cas_n));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_rc_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int PAUSE_US    = 100,
  parameter int WINDOW_US   = 64000,
  parameter int ROWS        = 4096,
  parameter int WAKE_CYCLES = 8,
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 3,
  parameter bit RAS_ONLY    = 1'b0,
  parameter int ROW_W       = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_req,
  input  logic             acc_done,
  output logic             acc_grant,
  output logic             ready,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int PAUSE_CLKS = CLK_MHZ * PAUSE_US;
  localparam int INTERVAL   = (CLK_MHZ * WINDOW_US) / ROWS;
  localparam int WW         = $clog2(WAKE_CYCLES + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctl_state_t st_q, st_d;
  logic [WW-1:0] wake_q, wake_d;
  logic pend_q, pend_d, viol_q, viol_d;
  logic pause_tick, ref_tick;
  logic seq_start, seq_busy, seq_done;
  logic in_init;

  assign in_init = (st_q == C_PAUSE) || (st_q == C_WAKE);

  rc_interval_timer #(.PERIOD(PAUSE_CLKS)) u_pause (
    .clk(clk), .rst_n(rst_int_n), .en(st_q == C_PAUSE), .tick(pause_tick));

  rc_interval_timer #(.PERIOD(INTERVAL)) u_interval (
    .clk(clk), .rst_n(rst_int_n), .en(1'b1), .tick(ref_tick));

  rc_strobe_seq #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .CBR(!RAS_ONLY)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(seq_start), .busy(seq_busy),
    .done(seq_done), .ras_n(ras_n), .cas_n(cas_n));

  generate
    if (RAS_ONLY) begin : g_row
      rc_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_int_n), .inc(seq_done), .row(row_addr));
    end else begin : g_no_row
      assign row_addr = '0;
    end
  endgenerate

  // Control next state.
  always_comb begin
    st_d      = st_q;
    seq_start = 1'b0;
    case (st_q)
      C_PAUSE: if (pause_tick) st_d = C_WAKE;
      C_WAKE: begin
        seq_start = !seq_busy;
        if (seq_done && wake_q == WW'(WAKE_CYCLES - 1)) st_d = C_IDLE;
      end
      C_IDLE: begin
        if (viol_q) st_d = C_WAKE;
        else if (pend_q) begin
          seq_start = 1'b1;
          st_d      = C_REFRESH;
        end else if (acc_req) st_d = C_ACCESS;
      end
      C_ACCESS:  if (acc_done) st_d = C_IDLE;
      C_REFRESH: if (seq_done) st_d = C_IDLE;
      default:   st_d = C_PAUSE;
    endcase
  end

  // Wake-up counter and refresh-due bookkeeping.
  always_comb begin
    wake_d = wake_q;
    if (st_q != C_WAKE) wake_d = '0;
    else if (seq_done)  wake_d = wake_q + 1'b1;

    pend_d = pend_q;
    viol_d = viol_q;
    if (in_init) begin
      pend_d = 1'b0;
      viol_d = 1'b0;
    end else begin
      if (st_q == C_IDLE && !viol_q && pend_q) pend_d = 1'b0;
      if (ref_tick) begin
        if (pend_d) viol_d = 1'b1;
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= C_PAUSE;
      wake_q <= '0;
      pend_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= wake_d;
      pend_q <= pend_d;
      viol_q <= viol_d;
    end
  end

  assign acc_grant = (st_q == C_ACCESS);
  assign ready     = !in_init;
  assign we_n      = 1'b1;
  assign oe_n      = 1'b1;

  p_no_grant_in_refresh_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_grant |-> (!seq_busy && ras_n && cas_n));
  p_quiet_pause_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == C_PAUSE) |-> (ras_n && cas_n && !seq_busy));
  p_ready_after_wake_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ready) |-> $past(seq_done));
  p_drop_on_violation_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(ready) |-> $past(viol_q));
endmodule

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb;
  localparam int PAUSE    = 50 * 100;
  localparam int INTERVAL = (50 * 64000) / 4096;
  localparam int T_CSR = 2, T_RAS = 4, T_RP = 3;
  localparam int B_ROWS = 16;

  logic clk, rst_n;
  logic acc_req, acc_done, acc_grant, ready, ras_n, cas_n, we_n, oe_n;
  logic [11:0] row_addr;
  logic b_grant, b_ready, b_ras_n, b_cas_n, b_we_n, b_oe_n;
  logic [3:0] b_row;

  int checks = 0, errors = 0;
  int cyc = 0;
  int falls = 0, first_fall = -1, falls_before_ready = 0;
  int cas_fall_cyc = 0, ras_fall_cyc = 0, ras_rise_cyc = -100;
  int overlap = 0;
  logic prev_ras = 1, prev_cas = 1, prev_b_ras = 1, seen_ready = 0;
  int exp_q[$];

  initial clk = 0;
  always #10 clk = ~clk;

  dram_refresh_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_done(acc_done),
    .acc_grant(acc_grant), .ready(ready), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .row_addr(row_addr));

  dram_refresh_ctrl #(.PAUSE_US(2), .WINDOW_US(16), .ROWS(B_ROWS), .RAS_ONLY(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .acc_req(1'b0), .acc_done(1'b0),
    .acc_grant(b_grant), .ready(b_ready), .ras_n(b_ras_n), .cas_n(b_cas_n),
    .we_n(b_we_n), .oe_n(b_oe_n), .row_addr(b_row));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver for the RAS-only scoreboard: expected row of each refresh cycle.
  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(i % B_ROWS);
  endtask

  // Monitor: strobe timing on the main instance.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (acc_grant && (!ras_n || !cas_n)) overlap++;
      if (prev_cas && !cas_n) cas_fall_cyc = cyc;
      if (prev_ras && !ras_n) begin
        falls++;
        if (first_fall < 0) first_fall = cyc;
        if (!seen_ready) falls_before_ready++;
        ras_fall_cyc = cyc;
        check(cas_n == 1'b0 && we_n && oe_n, "R4 strobes at ras fall", {cas_n, we_n, oe_n}, 3'b011);
        check(cyc - cas_fall_cyc == T_CSR, "R5 cas lead", cyc - cas_fall_cyc, T_CSR);
        check(cyc - ras_rise_cyc >= T_RP, "R5 precharge", cyc - ras_rise_cyc, T_RP);
      end
      if (!prev_ras && ras_n) begin
        ras_rise_cyc = cyc;
        check(cyc - ras_fall_cyc == T_RAS, "R5 ras width", cyc - ras_fall_cyc, T_RAS);
      end
      if (ready) seen_ready = 1;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  // Monitor: RAS-only scoreboard on the second instance.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_b_ras && !b_ras_n && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check(b_row == 4'(e), "R10 row sequence", b_row, e);
        check(b_cas_n == 1'b1, "R10 cas held high", b_cas_n, 1);
      end
      prev_b_ras = b_ras_n;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ras_fall();
    int f;
    f = falls;
    while (falls == f) @(negedge clk);
  endtask

  task automatic do_access(input int hold, output int falls_during);
    int f0;
    acc_req = 1;
    @(negedge clk);
    while (!acc_grant) @(negedge clk);
    check(acc_grant == 1'b1, "R7 grant after request", acc_grant, 1);
    acc_req = 0;
    f0 = falls;
    wait_cycles(hold);
    check(acc_grant == 1'b1, "R7 grant held until done", acc_grant, 1);
    falls_during = falls - f0;
    acc_done = 1;
    @(negedge clk);
    acc_done = 0;
  endtask

  initial begin
    fork
      begin
        wait_cycles(100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
  end

  initial begin
    int f0, fd;
    rst_n = 0;
    acc_req = 0;
    acc_done = 0;
    push_rows(24);
    wait_cycles(4);
    // R1: reset state
    check(ras_n && cas_n && we_n && oe_n, "R1 strobes idle", {ras_n, cas_n, we_n, oe_n}, 4'hf);
    check(!ready && !acc_grant, "R1 ready/grant low", {ready, acc_grant}, 0);
    check(row_addr == 0 && b_row == 0, "R1 row zero", b_row, 0);
    rst_n = 1;
    wait_cycles(2);
    check(ras_n && cas_n && !ready, "R1 after release", {ras_n, cas_n, ready}, 3'b110);

    while (!ready) @(negedge clk);
    check(first_fall >= PAUSE, "R2 pause length", first_fall, PAUSE);
    check(falls_before_ready == 8, "R3 wake burst count", falls_before_ready, 8);

    // R6: idle refresh rate
    f0 = falls;
    wait_cycles(10 * INTERVAL);
    check((falls - f0) >= 9 && (falls - f0) <= 11, "R6 refresh rate", falls - f0, 10);

    // R8: refresh deferred across one interval of access
    wait_ras_fall();
    f0 = falls;
    do_access(INTERVAL + 70, fd);
    check(fd == 0, "R8 no refresh during access", fd, 0);
    wait_cycles(20);
    check(falls - f0 == 1, "R8 deferred refresh issued", falls - f0, 1);
    check(ready == 1'b1, "R8 ready stays high", ready, 1);

    // R9: two intervals missed -> wake burst repeated
    wait_cycles(30);
    wait_ras_fall();
    do_access(2 * INTERVAL + 140, fd);
    check(fd == 0, "R9 no refresh during access", fd, 0);
    wait_cycles(4);
    check(ready == 1'b0, "R9 ready dropped", ready, 0);
    f0 = falls;
    while (!ready) @(negedge clk);
    check(falls - f0 == 8, "R9 wake burst repeated", falls - f0, 8);

    // R7: request from an idle bus after recovery
    wait_cycles(30);
    do_access(50, fd);
    check(overlap == 0, "R7 grant never overlaps strobes", overlap, 0);

    check(exp_q.size() == 0, "R10 row wrap reached", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule